// File: doc/BRIEF.md
# Interrupt-to-DMA Request Router

This block sits between a group of peripheral event sources and the rest of the interrupt and DMA machinery. It holds one byte of routing selection. For each implemented source, a selection bit of 1 turns that source's event into a one-cycle DMA request strobe. A selection bit of 0 turns the event into a sticky interrupt-pending flag. The sources are four port-input events, an A/D conversion-complete event, a serial transmit-empty event and a serial receive-full event. The remaining position is reserved.

Software writes the selection byte through a small byte-wide port and reads it back. A mode bit, sampled with each write strobe, picks one of two write rules. In the set-only rule, a written 1 sets a bit and a written 0 leaves it alone. In the direct rule, the written byte is stored as given.

When the DMA engine finishes a transfer for a source, it reports completion with a terminal-count flag and its own interrupt-enable for that channel. If both are set, the router clears that source's selection bit, so later events take the interrupt path. It also raises the source's pending flag in the same cycle, standing in for the interrupt that the DMA transfer replaced.

Top module: `evt_router_top`

## Requirements
- R1: After a synchronous reset, the selection byte reads 8'h00, every pending flag is 0 and no DMA strobe is active.
- R2: Bit positions are fixed: bit 7 to bit 4 are port inputs 7 to 4, bit 3 is reserved, bit 2 is A/D complete, bit 1 is serial transmit-empty and bit 0 is serial receive-full. Bit 3 always reads 0, writes to it are dropped, and an event on position 3 produces neither a strobe nor a pending flag.
- R3: With `wr_mode_i`=0 (set-only), a write ORs `wr_data_i` into the selection byte, so written zeros change nothing.
- R4: With `wr_mode_i`=1 (direct), a write replaces every implemented bit with the written value, so a written 0 clears a bit.
- R5: An event on a source whose selection bit is 1 drives that source's `dma_req_o` bit high for exactly the one cycle after the sampling edge, and it leaves the pending flag unchanged.
- R6: An event on a source whose selection bit is 0 sets its `irq_pend_o` bit one cycle after the sampling edge and drives no DMA strobe.
- R7: A pending flag stays set until `ack_i` carries a 1 in its position. If an ack and a new interrupt-path event for the same source arrive in the same cycle, the flag stays set.
- R8: A completion with `dma_tc_i` and `dma_ie_i` both 1 for a source clears its selection bit and sets its pending flag, both visible one cycle later.
- R9: A completion with terminal count but `dma_ie_i`=0 leaves the selection bit set and raises no pending flag.
- R10: When a completion clear and a software write hit the same bit in the same cycle, the bit ends up 0.
- R11: A completion strobe with `dma_tc_i`=0 changes neither the selection bit nor the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Selection byte write strobe |
| wr_mode_i | input | 1 | Write rule: 0 set-only, 1 direct |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current selection byte |
| ack_i | input | 8 | Write-1 acknowledge of pending flags |
| evt_i | input | 8 | Source event strobes, one per bit position |
| dma_done_i | input | 8 | DMA completion strobe per source |
| dma_tc_i | input | 8 | Terminal count reached, qualified by dma_done_i |
| dma_ie_i | input | 8 | DMA-side interrupt enable, qualified by dma_done_i |
| dma_req_o | output | 8 | One-cycle DMA request strobe per source |
| irq_pend_o | output | 8 | Sticky interrupt-pending flag per source |

## Verification
Every result is due one cycle after the edge that samples its stimulus. This covers the selection byte after a write or a completion clear, the DMA strobe after an event, and the pending flag after an event, ack or completion. The bench drives each stimulus on a falling edge and holds it through one rising edge. It removes the stimulus on the next falling edge and reads the outputs there, so it sees the strobe inside its single active cycle. A further idle cycle then confirms that the strobe has dropped while the flag and the byte hold.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;

  typedef enum logic {
    WM_SET_ONLY = 1'b0,
    WM_DIRECT   = 1'b1
  } wmode_e;

  localparam int unsigned LANE_W       = 8;
  localparam logic [7:0]  LANE_IMPL    = 8'hF7;

  function automatic logic [LANE_W-1:0] apply_write(
    input logic [LANE_W-1:0] cur,
    input logic [LANE_W-1:0] data,
    input wmode_e            mode,
    input logic [LANE_W-1:0] impl
  );
    logic [LANE_W-1:0] nxt;
    if (mode == WM_DIRECT) nxt = data;
    else                   nxt = cur | data;
    return nxt & impl;
  endfunction

endpackage

// File: rtl/evt_router_tc.sv
module evt_router_tc #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic [W-1:0] done_i,
  input  logic [W-1:0] tc_i,
  input  logic [W-1:0] ie_i,
  output logic [W-1:0] clr_o
);
  always_comb begin
    clr_o = done_i & tc_i & ie_i & IMPL;
  end
endmodule

// File: rtl/evt_router_sel.sv
module evt_router_sel
  import evt_router_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic         wr_mode_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] hw_clr_i,
  output logic [W-1:0] sel_o
);
  logic [W-1:0] sel_q;
  logic [W-1:0] sw_nxt;
  wmode_e       mode;

  always_comb begin
    mode   = wmode_e'(wr_mode_i);
    sw_nxt = wr_en_i ? apply_write(sel_q, wr_data_i, mode, IMPL) : sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sw_nxt & ~hw_clr_i & IMPL;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/evt_router_lane.sv
module evt_router_lane (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic sel_i,
  input  logic tc_fire_i,
  input  logic ack_i,
  output logic dma_req_o,
  output logic pend_o
);
  logic to_dma;
  logic to_irq;
  logic req_q;
  logic pend_q;

  always_comb begin
    to_dma = evt_i & sel_i;
    to_irq = (evt_i & ~sel_i) | tc_fire_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= to_dma;
      pend_q <= (pend_q & ~ack_i) | to_irq;
    end
  end

  assign dma_req_o = req_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/evt_router_top.sv
module evt_router_top
  import evt_router_pkg::*;
#(
  parameter int unsigned W    = LANE_W,
  parameter logic [W-1:0] IMPL = LANE_IMPL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic         wr_mode_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  input  logic [W-1:0] ack_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] dma_done_i,
  input  logic [W-1:0] dma_tc_i,
  input  logic [W-1:0] dma_ie_i,
  output logic [W-1:0] dma_req_o,
  output logic [W-1:0] irq_pend_o
);
  logic [W-1:0] hw_clr;
  logic [W-1:0] sel;

  evt_router_tc #(.W(W), .IMPL(IMPL)) u_tc (
    .done_i (dma_done_i),
    .tc_i   (dma_tc_i),
    .ie_i   (dma_ie_i),
    .clr_o  (hw_clr)
  );

  evt_router_sel #(.W(W), .IMPL(IMPL)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_mode_i (wr_mode_i),
    .wr_data_i (wr_data_i),
    .hw_clr_i  (hw_clr),
    .sel_o     (sel)
  );

  for (genvar i = 0; i < W; i++) begin : g_lane
    if (IMPL[i]) begin : g_impl
      evt_router_lane u_lane (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i[i]),
        .sel_i     (sel[i]),
        .tc_fire_i (hw_clr[i]),
        .ack_i     (ack_i[i]),
        .dma_req_o (dma_req_o[i]),
        .pend_o    (irq_pend_o[i])
      );
    end else begin : g_rsvd
      assign dma_req_o[i]  = 1'b0;
      assign irq_pend_o[i] = 1'b0;
    end
  end

  assign rd_data_o = sel;
endmodule

// File: rtl/evt_router_chk.sv
module evt_router_chk #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en_i,
  input logic         wr_mode_i,
  input logic [W-1:0] wr_data_i,
  input logic [W-1:0] rd_data_o,
  input logic [W-1:0] ack_i,
  input logic [W-1:0] evt_i,
  input logic [W-1:0] dma_done_i,
  input logic [W-1:0] dma_tc_i,
  input logic [W-1:0] dma_ie_i,
  input logic [W-1:0] dma_req_o,
  input logic [W-1:0] irq_pend_o
);
  logic [W-1:0] fire;
  assign fire = dma_done_i & dma_tc_i & dma_ie_i;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ((rd_data_o | dma_req_o | irq_pend_o) & ~IMPL) == '0);

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (IMPL[i]) begin : g_on
      p_dma_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        evt_i[i] && rd_data_o[i] |=> dma_req_o[i]);
      p_irq_path_r6: assert property (@(posedge clk) disable iff (rst)
        evt_i[i] && !rd_data_o[i] |=> irq_pend_o[i] && !dma_req_o[i]);
      p_pend_hold_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pend_o[i] && !ack_i[i] |=> irq_pend_o[i]);
      p_tc_clear_r8: assert property (@(posedge clk) disable iff (rst)
        fire[i] |=> !rd_data_o[i] && irq_pend_o[i]);
      p_tc_noie_r9: assert property (@(posedge clk) disable iff (rst)
        dma_done_i[i] && dma_tc_i[i] && !dma_ie_i[i] && !wr_en_i |=> $stable(rd_data_o[i]));
      p_set_only_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && !wr_mode_i && !fire[i] && (rd_data_o[i] || wr_data_i[i]) |=> rd_data_o[i]);
      p_direct_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && wr_mode_i && !fire[i] |=> rd_data_o[i] == $past(wr_data_i[i]));
    end
  end
endmodule

bind evt_router_top evt_router_chk #(.W(W), .IMPL(IMPL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en_i    (wr_en_i),
  .wr_mode_i  (wr_mode_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .ack_i      (ack_i),
  .evt_i      (evt_i),
  .dma_done_i (dma_done_i),
  .dma_tc_i   (dma_tc_i),
  .dma_ie_i   (dma_ie_i),
  .dma_req_o  (dma_req_o),
  .irq_pend_o (irq_pend_o)
);

// File: tb/tb_evt_router_top.sv
module tb_evt_router_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en_i, wr_mode_i;
  logic [7:0] wr_data_i, rd_data_o, ack_i, evt_i;
  logic [7:0] dma_done_i, dma_tc_i, dma_ie_i, dma_req_o, irq_pend_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_router_top dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_mode_i(wr_mode_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .ack_i(ack_i), .evt_i(evt_i),
    .dma_done_i(dma_done_i), .dma_tc_i(dma_tc_i), .dma_ie_i(dma_ie_i),
    .dma_req_o(dma_req_o), .irq_pend_o(irq_pend_o)
  );

  // {mode, write data, expected byte}
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 8'h01, 8'h01},   // R3
    {1'b0, 8'h80, 8'h81},   // R3
    {1'b0, 8'h00, 8'h81},   // R3 zeros ignored
    {1'b0, 8'hFF, 8'hF7},   // R2 bit 3 dropped
    {1'b1, 8'h24, 8'h24},   // R4
    {1'b1, 8'h08, 8'h00},   // R2 / R4
    {1'b0, 8'h12, 8'h12},   // R3
    {1'b1, 8'hF7, 8'hF7},   // R4
    {1'b0, 8'h00, 8'hF7},   // R3
    {1'b1, 8'h00, 8'h00}    // R4
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en_i = 0; wr_mode_i = 0; wr_data_i = 0; ack_i = 0; evt_i = 0;
    dma_done_i = 0; dma_tc_i = 0; dma_ie_i = 0; rst = 0;
  endtask

  // inputs already set at a falling edge; pass one rising edge, clear at next falling edge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 sel", rd_data_o, 8'h00);
    chk("R1 pend", irq_pend_o, 8'h00);
    chk("R1 dma", dma_req_o, 8'h00);

    for (int k = 0; k < 10; k++) begin
      wr_en_i = 1; wr_mode_i = VEC[k][16]; wr_data_i = VEC[k][15:8];
      step();
      chk("R3/R4 vec", rd_data_o, VEC[k][7:0]);
    end

    // interrupt path on all positions, reserved one silent
    evt_i = 8'hFF; step();
    chk("R6 pend", irq_pend_o, 8'hF7);
    chk("R6 no dma", dma_req_o, 8'h00);
    // ack with simultaneous event keeps flag
    ack_i = 8'h01; evt_i = 8'h01; step();
    chk("R7 ack+evt", irq_pend_o, 8'hF7);
    step();
    chk("R7 sticky", irq_pend_o, 8'hF7);
    ack_i = 8'hF7; step();
    chk("R7 ack", irq_pend_o, 8'h00);

    // DMA path
    wr_en_i = 1; wr_mode_i = 1; wr_data_i = 8'h45; step();
    chk("R4 set", rd_data_o, 8'h45);
    evt_i = 8'h45; step();
    chk("R5 strobe", dma_req_o, 8'h45);
    chk("R5 no pend", irq_pend_o, 8'h00);
    step();
    chk("R5 one cycle", dma_req_o, 8'h00);

    // completion: bit0 tc+ie, bit6 no tc
    dma_done_i = 8'h41; dma_tc_i = 8'h01; dma_ie_i = 8'h41; step();
    chk("R8/R11 sel", rd_data_o, 8'h44);
    chk("R8/R11 pend", irq_pend_o, 8'h01);
    // tc but interrupt disabled
    dma_done_i = 8'h04; dma_tc_i = 8'h04; dma_ie_i = 8'h00; step();
    chk("R9 sel", rd_data_o, 8'h44);
    chk("R9 pend", irq_pend_o, 8'h01);
    // hardware clear beats simultaneous write
    dma_done_i = 8'h04; dma_tc_i = 8'h04; dma_ie_i = 8'h04;
    wr_en_i = 1; wr_mode_i = 0; wr_data_i = 8'h04; step();
    chk("R10 sel", rd_data_o, 8'h40);
    chk("R10/R8 pend", irq_pend_o, 8'h05);
    // event after clear takes interrupt path
    evt_i = 8'h04; step();
    chk("R8 reroute dma", dma_req_o, 8'h00);

    // reset mid-run
    rst = 1; step();
    chk("R1 sel again", rd_data_o, 8'h00);
    chk("R1 pend again", irq_pend_o, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule